// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Age-Based Replacement

This block is a read-only cache that sits between a requester and a slower word-wide memory. Each request carries a byte address. The low bits select a byte within a word and are ignored. The middle bits pick one set. The remaining upper bits form the tag. The tags of all ways in the chosen set are compared in parallel. On a hit, the word held by the matching way is returned one cycle after the request is accepted, and memory is not used.

On a miss, the block raises a memory request for the word-aligned address. It waits for the memory to return the word, writes that word into a victim way of the set, and returns it to the requester marked as a miss. The victim is chosen from a small age counter kept for each way. An access clears the age of the way it uses and ages every other way of the same set by one. The counters stop at their maximum value. An empty way is always filled before an occupied way is evicted.

The requester sees one access in flight at a time: `req_ready` is low from the moment a miss is accepted until its reply is delivered. The word width, the number of sets, the number of ways and the counter width are parameters.

Top module: `sa_read_cache`

## Requirements
- R1: The byte address is split as follows. Bits [1:0] select a byte and have no effect on lookup or on the returned word. Bits [INDEX_W+1:2] select the set. Bits [31:INDEX_W+2] are the tag. With the default INDEX_W of 8 the tag is 22 bits wide.
- R2: After reset every way is empty, so the first access to any address is a miss.
- R3: An accepted request hits when a valid way of its set holds its tag. At most one way can match. The next cycle shows `rsp_valid`=1, `rsp_hit`=1 and that way's stored word on `rsp_data`, and `mem_req` stays low for the whole access.
- R4: On a hit, the age of the matching way becomes 0. Every other way in that set ages by one and stops at 3. Ways in other sets are untouched.
- R5: On a miss, `mem_req` rises in the cycle after acceptance, with `mem_addr` equal to the request address with bits [1:0] cleared. Both hold steady until a cycle with `mem_rvalid`=1.
- R6: The cycle after `mem_rvalid` is seen, the reply shows `rsp_valid`=1, `rsp_hit`=0 and the returned memory word. From acceptance of the miss until that reply, `req_ready` is 0.
- R7: The victim of a miss is the lowest-numbered empty way of the set. When no way is empty, it is the way with the greatest age, and ties go to the lowest way number.
- R8: The refilled way becomes valid with the new tag and word, and counts as accessed. Its age becomes 0 and the other ways of the set age by one, saturating. A repeat of the same access therefore hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup is offered this cycle |
| req_ready | output | 1 | A lookup can be accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_hit | output | 1 | Reply was served from the cache |
| rsp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | Refill fetch pending |
| mem_addr | output | ADDR_W | Word-aligned refill address |
| mem_rvalid | input | 1 | Memory word is present this cycle |
| mem_rdata | input | DATA_W | Word from memory |

## Verification
The bench builds a cache with four sets and drives it with several kinds of traffic. A cold sweep across every set separates a correct reset of the valid bits from stale contents. A directed fill of four tags into one set, followed by hits in a chosen order and one extra tag, shows whether the evicted way follows the ages rather than the fill order or the way number, and whether saturated ties resolve toward way 0. A long pseudo-random stream draws six tags per set, varies the byte offsets and the memory latency, and is scored against an age model held in the bench, so any wrong aging, victim choice, offset handling or refill timing shows up as a mismatched hit flag, word or fetch address.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

   typedef enum logic {
      ST_LOOKUP = 1'b0,
      ST_REFILL = 1'b1
   } ctl_state_e;

   function automatic int way_bits(input int ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction

endpackage

// File: rtl/sa_tag_match.sv
module sa_tag_match #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 22,
   parameter int DATA_W = 32,
   localparam int WAY_W = sa_cache_pkg::way_bits(WAYS)
) (
   input  logic [WAYS-1:0]             set_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
   input  logic [WAYS-1:0][DATA_W-1:0] set_words,
   input  logic [TAG_W-1:0]            probe_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic                        hit_any,
   output logic [WAY_W-1:0]            hit_way,
   output logic [DATA_W-1:0]           hit_word
);

   // one comparator per way, all working on the same set
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = set_valid[w] && (set_tags[w] == probe_tag);
   end

   assign hit_any = |hit_vec;

   // way-select multiplexer driven by the match vector
   always_comb begin
      hit_way  = '0;
      hit_word = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_way  = WAY_W'(w);
            hit_word = set_words[w];
         end
      end
   end

endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
   parameter int WAYS  = 4,
   parameter int AGE_W = 2,
   localparam int WAY_W = sa_cache_pkg::way_bits(WAYS)
) (
   input  logic [WAYS-1:0]            set_valid,
   input  logic [WAYS-1:0][AGE_W-1:0] set_ages,
   output logic [WAY_W-1:0]           victim_way
);

   if (WAYS == 1) begin : g_direct
      assign victim_way = '0;
   end else begin : g_assoc
      logic [WAY_W-1:0] empty_way;
      logic             empty_found;
      logic [WAY_W-1:0] oldest_way;
      logic [AGE_W-1:0] oldest_age;

      // lowest-numbered empty way
      always_comb begin
         empty_way   = '0;
         empty_found = 1'b0;
         for (int w = 0; w < WAYS; w++) begin
            if (!set_valid[w] && !empty_found) begin
               empty_way   = WAY_W'(w);
               empty_found = 1'b1;
            end
         end
      end

      // greatest age, strict compare keeps the lowest way on ties
      always_comb begin
         oldest_way = '0;
         oldest_age = set_ages[0];
         for (int w = 1; w < WAYS; w++) begin
            if (set_ages[w] > oldest_age) begin
               oldest_age = set_ages[w];
               oldest_way = WAY_W'(w);
            end
         end
      end

      assign victim_way = empty_found ? empty_way : oldest_way;
   end

endmodule

// File: rtl/sa_age_step.sv
module sa_age_step #(
   parameter int WAYS  = 4,
   parameter int AGE_W = 2,
   localparam int WAY_W = sa_cache_pkg::way_bits(WAYS),
   localparam logic [AGE_W-1:0] AGE_TOP = {AGE_W{1'b1}}
) (
   input  logic [WAYS-1:0][AGE_W-1:0] ages_cur,
   input  logic [WAY_W-1:0]           touched_way,
   output logic [WAYS-1:0][AGE_W-1:0] ages_next
);

   for (genvar w = 0; w < WAYS; w++) begin : g_age
      always_comb begin
         if (touched_way == WAY_W'(w))
            ages_next[w] = '0;
         else if (ages_cur[w] == AGE_TOP)
            ages_next[w] = AGE_TOP;
         else
            ages_next[w] = ages_cur[w] + 1'b1;
      end
   end

endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 8,
   parameter int WAYS    = 4,
   parameter int AGE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   import sa_cache_pkg::*;

   localparam int OFFSET_W = $clog2(DATA_W / 8);
   localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;
   localparam int SETS     = 1 << INDEX_W;
   localparam int WAY_W    = way_bits(WAYS);
   localparam int WORD_W   = ADDR_W - OFFSET_W;

   initial begin
      assert (DATA_W % 8 == 0 && DATA_W >= 16) else $error("DATA_W must be a whole number of bytes, at least two");
      assert (TAG_W >= 1) else $error("INDEX_W leaves no tag bits");
      assert ((1 << $clog2(WAYS)) == WAYS) else $error("WAYS must be a power of two");
      assert ((1 << AGE_W) >= WAYS) else $error("AGE_W too narrow to rank every way");
   end

   // storage: valid and age reset, tag and word arrays do not
   logic [WAYS-1:0]             valid_q [SETS];
   logic [WAYS-1:0][AGE_W-1:0]  age_q   [SETS];
   logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
   logic [WAYS-1:0][DATA_W-1:0] word_q  [SETS];

   ctl_state_e           state_q;
   logic [INDEX_W-1:0]   fill_idx_q;
   logic [TAG_W-1:0]     fill_tag_q;
   logic [WORD_W-1:0]    fill_word_q;

   // request address fields
   logic [INDEX_W-1:0]   req_idx;
   logic [TAG_W-1:0]     req_tag;
   assign req_idx = req_addr[OFFSET_W +: INDEX_W];
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

   // the set being looked at: the request's set, or the set under refill
   logic [INDEX_W-1:0]   lk_idx;
   assign lk_idx = (state_q == ST_REFILL) ? fill_idx_q : req_idx;

   logic [WAYS-1:0]             set_valid;
   logic [WAYS-1:0][AGE_W-1:0]  set_ages;
   logic [WAYS-1:0][TAG_W-1:0]  set_tags;
   logic [WAYS-1:0][DATA_W-1:0] set_words;
   assign set_valid = valid_q[lk_idx];
   assign set_ages  = age_q[lk_idx];
   assign set_tags  = tag_q[lk_idx];
   assign set_words = word_q[lk_idx];

   logic [WAYS-1:0]   lk_hit_vec;
   logic              lk_hit;
   logic [WAY_W-1:0]  lk_hit_way;
   logic [DATA_W-1:0] lk_hit_word;

   sa_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
      .set_valid (set_valid),
      .set_tags  (set_tags),
      .set_words (set_words),
      .probe_tag (req_tag),
      .hit_vec   (lk_hit_vec),
      .hit_any   (lk_hit),
      .hit_way   (lk_hit_way),
      .hit_word  (lk_hit_word)
   );

   logic [WAY_W-1:0] vic_way;

   sa_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
      .set_valid  (set_valid),
      .set_ages   (set_ages),
      .victim_way (vic_way)
   );

   logic [WAY_W-1:0]           touch_way;
   logic [WAYS-1:0][AGE_W-1:0] ages_nxt;
   assign touch_way = (state_q == ST_REFILL) ? vic_way : lk_hit_way;

   sa_age_step #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
      .ages_cur    (set_ages),
      .touched_way (touch_way),
      .ages_next   (ages_nxt)
   );

   logic accept;
   logic refill_done;
   assign req_ready   = (state_q == ST_LOOKUP);
   assign accept      = req_ready && req_valid;
   assign refill_done = (state_q == ST_REFILL) && mem_rvalid;
   assign mem_req     = (state_q == ST_REFILL);
   assign mem_addr    = {fill_word_q, {OFFSET_W{1'b0}}};

   // control, valid bits and ages
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_LOOKUP;
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_data    <= '0;
         fill_idx_q  <= '0;
         fill_tag_q  <= '0;
         fill_word_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            age_q[s]   <= '0;
         end
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_LOOKUP: begin
               if (accept) begin
                  if (lk_hit) begin
                     age_q[lk_idx] <= ages_nxt;
                     rsp_valid     <= 1'b1;
                     rsp_hit       <= 1'b1;
                     rsp_data      <= lk_hit_word;
                  end else begin
                     state_q     <= ST_REFILL;
                     fill_idx_q  <= req_idx;
                     fill_tag_q  <= req_tag;
                     fill_word_q <= req_addr[ADDR_W-1:OFFSET_W];
                  end
               end
            end
            ST_REFILL: begin
               if (mem_rvalid) begin
                  valid_q[lk_idx][vic_way] <= 1'b1;
                  age_q[lk_idx]            <= ages_nxt;
                  rsp_valid                <= 1'b1;
                  rsp_hit                  <= 1'b0;
                  rsp_data                 <= mem_rdata;
                  state_q                  <= ST_LOOKUP;
               end
            end
            default: state_q <= ST_LOOKUP;
         endcase
      end
   end

   // tag and word arrays are written only on refill
   always_ff @(posedge clk) begin
      if (refill_done) begin
         tag_q[fill_idx_q][vic_way]  <= fill_tag_q;
         word_q[fill_idx_q][vic_way] <= mem_rdata;
      end
   end

   // R3: no two ways of one set may match the same tag
   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $onehot0(lk_hit_vec));

   // R3: a hit replies next cycle without touching memory
   p_hit_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lk_hit) |=> (rsp_valid && rsp_hit && !mem_req));

   // R4: the way that hit ends up youngest
   p_age_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lk_hit) |=> (age_q[$past(lk_idx)][$past(lk_hit_way)] == '0));

   // R5: fetch address holds while memory has not answered
   p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R6: refill reply carries the memory word and frees the requester
   p_refill_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid) |=> (rsp_valid && !rsp_hit && req_ready
                                   && rsp_data == $past(mem_rdata)));

   // R7: an occupied way is never chosen while an empty one exists
   p_empty_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (&set_valid || !set_valid[vic_way]));

   // R8: refilled way is valid and youngest afterwards
   p_refill_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid) |=> (valid_q[$past(lk_idx)][$past(vic_way)]
                                   && age_q[$past(lk_idx)][$past(vic_way)] == '0));

endmodule

// File: tb/sa_read_cache_test.sv
module sa_read_cache_test;

   localparam int IW   = 2;
   localparam int NSET = 1 << IW;
   localparam int NWAY = 4;
   localparam int TW   = 32 - IW - 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [31:0] rsp_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2 clk = ~clk;   // 250 MHz

   sa_read_cache #(.ADDR_W(32), .DATA_W(32), .INDEX_W(IW), .WAYS(NWAY), .AGE_W(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // reference model of the requirements
   bit          m_valid [NSET][NWAY];
   logic [TW-1:0] m_tag [NSET][NWAY];
   int          m_age   [NSET][NWAY];
   logic [31:0] lfsr = 32'hACE1_2468;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return w * 32'h9E37_79B1 + 32'h0123_4567;
   endfunction

   function automatic logic [31:0] mk_addr(input int tg, input int idx, input int off);
      return (32'(tg) << (IW + 2)) | (32'(idx) << 2) | 32'(off & 3);
   endfunction

   function automatic logic [31:0] next_rand();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr;
   endfunction

   // R7: empty way first, then greatest age, ties to the lowest way
   function automatic int model_victim(input int idx);
      int best;
      for (int w = 0; w < NWAY; w++)
         if (!m_valid[idx][w]) return w;
      best = 0;
      for (int w = 1; w < NWAY; w++)
         if (m_age[idx][w] > m_age[idx][best]) best = w;
      return best;
   endfunction

   task automatic do_access(input logic [31:0] a, input int lat, input string req);
      int          idx;
      logic [TW-1:0] tg;
      bit          exp_hit;
      int          way;
      bit          got_hit;
      logic [31:0] got_data;
      bit          saw_mem;
      bit          done;
      int          cnt;
      idx = int'(a[IW+1:2]);
      tg  = a[31:IW+2];
      exp_hit = 1'b0;
      way = 0;
      for (int w = 0; w < NWAY; w++)
         if (m_valid[idx][w] && m_tag[idx][w] == tg) begin
            exp_hit = 1'b1;
            way = w;
         end
      if (!exp_hit) way = model_victim(idx);

      @(negedge clk);
      check(req_ready == 1'b1, "R6", "ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      #1 req_valid = 1'b0;

      saw_mem = 1'b0;
      done    = 1'b0;
      cnt     = 0;
      got_hit = 1'b0;
      got_data = '0;
      while (!done) begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (rsp_valid) begin
            got_hit  = rsp_hit;
            got_data = rsp_data;
            done     = 1'b1;
         end else if (mem_req) begin
            if (!saw_mem) begin
               saw_mem = 1'b1;
               // R5: word-aligned fetch address
               check(mem_addr == {a[31:2], 2'b00}, "R5", "fetch address", mem_addr, {a[31:2], 2'b00});
               // R6: no new request taken during refill
               check(req_ready == 1'b0, "R6", "ready during refill", 32'(req_ready), 32'd0);
            end
            if (cnt == lat) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_word(a);
            end
            cnt++;
         end
      end

      check(got_hit == exp_hit, req, "hit flag", 32'(got_hit), 32'(exp_hit));
      check(got_data == mem_word(a), req, "returned word", got_data, mem_word(a));
      check(saw_mem == !exp_hit, "R3", "memory used only on miss", 32'(saw_mem), 32'(!exp_hit));

      // R4 / R8 model update: touched way youngest, others age and saturate
      for (int w = 0; w < NWAY; w++)
         if (w == way) m_age[idx][w] = 0;
         else if (m_age[idx][w] < 3) m_age[idx][w] = m_age[idx][w] + 1;
      if (!exp_hit) begin
         m_valid[idx][way] = 1'b1;
         m_tag[idx][way]   = tg;
      end
   endtask

   initial begin
      for (int s = 0; s < NSET; s++)
         for (int w = 0; w < NWAY; w++) begin
            m_valid[s][w] = 1'b0;
            m_tag[s][w]   = '0;
            m_age[s][w]   = 0;
         end

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R2", "reset ready", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R2", "reset reply strobe", 32'(rsp_valid), 32'd0);
      check(mem_req == 1'b0, "R2", "reset fetch", 32'(mem_req), 32'd0);

      // R2: cold sweep, every set misses once
      for (int s = 0; s < NSET; s++) do_access(mk_addr(1, s, s), s % 3, "R2");

      // R1 / R3: fill set 0 with tags 1..4, then hit with other byte offsets
      for (int t = 2; t <= 4; t++) do_access(mk_addr(t, 0, 0), 1, "R7");
      for (int t = 1; t <= 4; t++) do_access(mk_addr(t, 0, 3 - (t % 4)), 0, "R1");
      // R7: ages now 3,2,1,0 by way; tag 5 must evict tag 1
      do_access(mk_addr(5, 0, 0), 2, "R7");
      // R8: the refilled word hits at once
      do_access(mk_addr(5, 0, 1), 0, "R8");
      do_access(mk_addr(1, 0, 0), 0, "R7");

      // R4: set 2, fill tags 2..4, touch tag 1, then tag 6 evicts tag 2
      for (int t = 2; t <= 4; t++) do_access(mk_addr(t, 2, 0), 0, "R4");
      do_access(mk_addr(1, 2, 2), 0, "R4");
      do_access(mk_addr(6, 2, 0), 1, "R4");
      do_access(mk_addr(1, 2, 0), 0, "R4");
      do_access(mk_addr(2, 2, 0), 0, "R4");

      // near-exhaustive random stream over six tags per set
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = next_rand();
         do_access(mk_addr(int'(r[2:0]) % 6, int'(r[5:4]), int'(r[9:8])), int'(r[13:12]), "R7");
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule